// File: doc/BRIEF.md
# Two-Stage Cascaded Watchdog

This block watches for a stalled program. Two 8-bit down-counters are chained: a low stage and a high stage. When the high stage passes below zero, the block raises a registered internal reset pulse that lasts a fixed number of cycles. Software restarts the count by writing the control register; the value written does not matter for the count. The high stage takes its steps from one of two sources. It can step on each low-stage wrap, which gives a long 16-bit timeout, or on every prescaled tick, which skips the low stage and gives a short 8-bit timeout. Bit 7 of the control register picks the source at run time.

Four configuration pins are captured while the external reset is held. After that they are fixed. They pick the count clock: a slow-oscillator strobe, or every system clock, each divided by 16 in a 4-bit prescaler. They can switch the watchdog off for good. They give the reset value of the source select. They also set what a stop request does: halt the count, or force an internal reset.

The block has no streaming data path. Every pin is a plain control or status signal with no handshake.

Top module: `cascade_wdt`

## Requirements
- R1: While `rst_ni` is low and just after it rises, `wdt_rst_o` is 0 and `ctl_rdata_o` reads `{cfg_i[2], 0, 6'b111111}`.
- R2: A cycle with `ctl_wr_i` high loads both stages with all ones and clears the prescaler. Bit 7 takes `ctl_wdata_i[7]`, and bits 6:0 of the written data are ignored. On the next cycle the register reads `{ctl_wdata_i[7], 0, 6'b111111}`.
- R3: Bypass mode (bit 7 = 1) with the system clock selected: `wdt_rst_o` rises exactly 2^PRE_W × 256 clock edges after the restart edge. That is 4096 edges at the defaults.
- R4: Cascaded mode (bit 7 = 0) with the system clock selected: `wdt_rst_o` rises exactly 2^PRE_W × 2^LO_W × 256 edges after the restart edge. That is 16 × 65536 edges at the defaults.
- R5: `cfg_i[0]` = 1 counts every clock and ignores `slow_tick_i`. `cfg_i[0]` = 0 advances the prescaler only on cycles where `slow_tick_i` is high.
- R6: With `cfg_i[1]` = 1 the counters never move and no timeout reset occurs. Writes still set bit 7, and bits 5:0 read as 6'b111111.
- R7: `cfg_i` is sampled only while `rst_ni` is low. Later changes have no effect on mode, clock or timeout.
- R8: With `cfg_i[3]` = 0, the prescaler and both stages are frozen on every cycle where `stop_req_i` is high. Each frozen edge lengthens the timeout by one edge.
- R9: With `cfg_i[3]` = 1, a cycle with `stop_req_i` high makes `wdt_rst_o` high after that clock edge.
- R10: Each internal reset pulse lasts exactly RST_CYC cycles (4 by default). Once it ends, the register reads `{cfg_i[2] as sampled, 0, 6'b111111}` and counting starts again.
- R11: Bits 5:0 of the read value are bits 7:2 of the high stage. In bypass mode with the system clock, they read 6'b111111 63 edges after a restart and 6'b111110 64 edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | External synchronous reset, active low; captures `cfg_i` |
| cfg_i | input | 4 | [0] clock select (1 = system), [1] watchdog off, [2] reset value of source select, [3] stop request forces reset |
| slow_tick_i | input | 1 | One-cycle strobe from the slow oscillator domain |
| stop_req_i | input | 1 | Stop request, level sensitive |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Write data; only bit 7 is kept |
| ctl_rdata_o | output | 8 | {source select, 0, high stage [7:2]} |
| wdt_rst_o | output | 1 | Internal reset pulse |

## Verification
The assertions take for granted that every input is synchronous to `clk_i` and known once the external reset has been released. They also assume `slow_tick_i` is a strobe, so a single cycle high counts as one oscillator event. The bench changes every input on the falling edge and holds `slow_tick_i` high for one cycle per period. It also keeps stop requests and writes apart from the cycles of an internal reset pulse, except where that overlap is itself under test.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Bit order matches cfg_i[3:0]
  typedef struct packed {
    logic stop_rst;  // [3] stop request forces reset
    logic sel_init;  // [2] reset value of source select
    logic wdt_off;   // [1] watchdog never runs
    logic clk_fast;  // [0] count clock is the system clock
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic tick_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (clr_i)       cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = step_i && (cnt_q == '1);

  // R5
  pre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_cascade.sv
module wdt_cascade #(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            tick_i,
  input  logic            bypass_i,
  output logic [HI_W-1:0] hi_o,
  output logic            fire_o
);
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            lo_wrap, hi_step;

  assign lo_wrap = tick_i && !bypass_i && (lo_q == '0);
  assign hi_step = bypass_i ? tick_i : lo_wrap;
  assign fire_o  = hi_step && (hi_q == '0);
  assign hi_o    = hi_q;

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      lo_q <= '1;
      hi_q <= '1;
    end else begin
      if (tick_i && !bypass_i) lo_q <= lo_q - 1'b1;
      if (hi_step)             hi_q <= hi_q - 1'b1;
    end
  end

  // R4
  hi_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (hi_q == $past(hi_q) || hi_q == $past(hi_q) - 1'b1 || $past(hi_q) == '0));
  // R3
  lo_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i && !load_i) |=> $stable(lo_q));
endmodule

// File: rtl/wdt_stretch.sv
module wdt_stretch #(
  parameter int RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(RST_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pulse_o <= 1'b0;
      cnt_q   <= '0;
    end else if (trig_i) begin
      pulse_o <= 1'b1;
      cnt_q   <= CW'(RST_CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end else begin
      pulse_o <= 1'b0;
    end
  end

  // R10
  pulse_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |=> pulse_o);
endmodule

// File: rtl/cascade_wdt.sv
module cascade_wdt #(
  parameter int PRE_W   = 4,
  parameter int LO_W    = 8,
  parameter int RST_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] cfg_i,
  input  logic       slow_tick_i,
  input  logic       stop_req_i,
  input  logic       ctl_wr_i,
  input  logic [7:0] ctl_wdata_i,
  output logic [7:0] ctl_rdata_o,
  output logic       wdt_rst_o
);
  import wdt_pkg::*;
  localparam int HI_W = 8;

  wdt_cfg_t        cfg_q;
  logic            sel_q;
  logic            init, clr, run, step, tick, timer_fire, stop_fire;
  logic [HI_W-1:0] hi_cnt;
  logic            unused_bits;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cfg_q <= wdt_cfg_t'(cfg_i);
  end

  assign init = !rst_ni || wdt_rst_o;
  assign clr  = init || ctl_wr_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        sel_q <= cfg_i[2];
    else if (wdt_rst_o) sel_q <= cfg_q.sel_init;
    else if (ctl_wr_i)  sel_q <= ctl_wdata_i[7];
  end

  assign run  = !cfg_q.wdt_off && !(stop_req_i && !cfg_q.stop_rst);
  assign step = run && (cfg_q.clk_fast || slow_tick_i);

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr), .step_i(step), .tick_o(tick)
  );

  wdt_cascade #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(clr), .tick_i(tick),
    .bypass_i(sel_q), .hi_o(hi_cnt), .fire_o(timer_fire)
  );

  assign stop_fire = rst_ni && stop_req_i && cfg_q.stop_rst;

  wdt_stretch #(.RST_CYC(RST_CYC)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .trig_i((timer_fire && !cfg_q.wdt_off) || stop_fire), .pulse_o(wdt_rst_o)
  );

  assign ctl_rdata_o = {sel_q, 1'b0, hi_cnt[HI_W-1 -: 6]};
  assign unused_bits = ^{ctl_wdata_i[6:0], hi_cnt[1:0]};

  // R6
  wdt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.wdt_off |-> !timer_fire);
  // R2
  wr_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !wdt_rst_o) |=> (ctl_rdata_o[6:0] == 7'h3F && ctl_rdata_o[7] == $past(ctl_wdata_i[7])));
  // R9
  stop_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_req_i && cfg_q.stop_rst) |=> wdt_rst_o);
  // R8
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_req_i && !cfg_q.stop_rst && !ctl_wr_i && !wdt_rst_o) |=> $stable(ctl_rdata_o));
  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(cfg_q));
endmodule

// File: tb/test_cascade_wdt.sv
module test_cascade_wdt;
  localparam int PRE_W = 4, LO_W = 2, RST_CYC = 4;
  localparam int T_BYP = (1 << PRE_W) * 256;
  localparam int T_CAS = (1 << PRE_W) * (1 << LO_W) * 256;

  typedef struct packed {
    logic [3:0]  cfg;
    logic        wr;
    logic        sel;
    logic [7:0]  ratio;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{4'b0001, 1'b1, 1'b1, 8'd3, 32'(T_BYP)},      // R3 R5: slow strobe ignored
    '{4'b0001, 1'b1, 1'b0, 8'd3, 32'(T_CAS)},      // R4
    '{4'b0101, 1'b0, 1'b0, 8'd1, 32'(T_BYP)},      // R1: reset value selects bypass
    '{4'b0000, 1'b1, 1'b1, 8'd4, 32'(T_BYP * 4)},  // R5: slow clock
    '{4'b0101, 1'b1, 1'b0, 8'd1, 32'(T_CAS)}       // R2: write overrides reset value
  };

  logic       clk = 0, rst_ni = 0, slow_tick = 0, stop_req = 0, ctl_wr = 0;
  logic [3:0] cfg = 4'b0001;
  logic [7:0] wdata = 0, rdata;
  logic       wdt_rst;
  int total = 0, bad = 0, ratio_cur = 1, ph = 0, cyc = 0;

  cascade_wdt #(.PRE_W(PRE_W), .LO_W(LO_W), .RST_CYC(RST_CYC)) i_cascade_wdt (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_i(cfg), .slow_tick_i(slow_tick),
    .stop_req_i(stop_req), .ctl_wr_i(ctl_wr), .ctl_wdata_i(wdata),
    .ctl_rdata_o(rdata), .wdt_rst_o(wdt_rst)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(negedge clk);
      ph = ph + 1;
      if (ph >= ratio_cur) ph = 0;
      slow_tick = (ph == 0);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] c);
    @(negedge clk); rst_ni = 0; cfg = c; stop_req = 0; ctl_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1;
  endtask

  task automatic do_write(input logic [7:0] d);
    ctl_wr = 1; wdata = d;
    @(posedge clk); @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic edges(input int k);
    repeat (k) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wait_fire(inout int n);
    while (!wdt_rst && n < 40000) begin @(posedge clk); n++; @(negedge clk); end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (wdt_rst && w < 20) begin w++; @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    int n, w;
    logic [7:0] r0;

    // R1: reset state
    do_reset(4'b0101);
    chk("R1 rd", rdata, 8'hBF);
    chk("R1 rst", wdt_rst, 0);
    do_reset(4'b0001);
    chk("R1 rd0", rdata, 8'h3F);

    // Vector table: timeout length and pulse shape
    for (int i = 0; i < 5; i++) begin
      ratio_cur = VEC[i].ratio;
      do_reset(VEC[i].cfg);
      if (VEC[i].wr) do_write({VEC[i].sel, 7'b1010101});
      n = 0;
      wait_fire(n);
      total++;
      if (n > VEC[i].exp || n + (VEC[i].cfg[0] ? 0 : VEC[i].ratio - 1) < VEC[i].exp) begin
        bad++;
        $display("FAIL R3/R4/R5 vec %0d act=%0d exp=%0d", i, n, VEC[i].exp);
      end
      pulse_width(w);
      chk("R10 width", w, RST_CYC);
      chk("R10 reinit", rdata, {VEC[i].cfg[2], 7'h3F});
    end
    ratio_cur = 1;

    // R2 and R11: readback and write reload
    do_reset(4'b0001);
    do_write(8'h80);
    edges(63);
    chk("R11 63", rdata, 8'hBF);
    edges(1);
    chk("R11 64", rdata, 8'hBE);
    do_write(8'h7F);
    chk("R2 reload", rdata, 8'h3F);

    // R7: cfg changes after reset ignored
    do_reset(4'b0001);
    cfg = 4'b1110;
    do_write(8'h80);
    n = 0; wait_fire(n);
    chk("R7 timeout", n, T_BYP);
    pulse_width(w);

    // R6: watchdog off
    do_reset(4'b0011);
    do_write(8'h80);
    edges(T_BYP + 200);
    chk("R6 norst", wdt_rst, 0);
    chk("R6 rd", rdata, 8'hBF);
    do_write(8'h00);
    chk("R6 wr", rdata, 8'h3F);

    // R8: stop request freezes
    do_reset(4'b0001);
    do_write(8'h80);
    n = 0;
    repeat (100) begin @(posedge clk); n++; @(negedge clk); end
    stop_req = 1;
    r0 = rdata;
    repeat (300) begin @(posedge clk); n++; @(negedge clk); end
    chk("R8 frozen", rdata, r0);
    stop_req = 0;
    wait_fire(n);
    chk("R8 timeout", n, T_BYP + 300);
    pulse_width(w);

    // R9: stop request forces reset
    do_reset(4'b1001);
    do_write(8'h00);
    edges(10);
    stop_req = 1;
    @(posedge clk); @(negedge clk);
    stop_req = 0;
    chk("R9 rst", wdt_rst, 1);
    pulse_width(w);
    chk("R9 width", w, RST_CYC);
    chk("R9 reinit", rdata, 8'h3F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=<190000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule